// File: doc/BRIEF.md
# Polled Interrupt Request Scanner

This block finds which of a set of registered interrupt request lines needs service by polling the lines one at a time. All request lines are reduced by an OR into one any-request flag, which a controller tests with a one-clock test strobe. If the flag is set when the strobe arrives, the block starts a polling pass. The pass begins at index 0, and each clock it examines one line through a multiplexer and then advances the index by one. The pass stops on the first active line it reaches. The block reports that line's number with a one-clock valid pulse and goes back to idle.

Priority comes only from position: line 0 is examined first, so it has the highest priority. An active line waits one clock for every inactive line ahead of it. The reported line number stays fixed until the controller acknowledges it. Until that acknowledge, further test strobes are ignored, so a second result cannot overwrite a result that has not been read.

States: `ST_IDLE` (waiting for a strobe), `ST_SCAN` (one line examined per clock), `ST_FOUND` (valid pulse). Transitions: IDLE→SCAN on strobe with any-request set and no unacknowledged result; SCAN→FOUND when the selected line is active; SCAN→IDLE when the last index is reached and that line is inactive; SCAN→SCAN otherwise, with the index incremented; FOUND→IDLE always.

Top module: `poll_scanner`

## Requirements
- R1: `any_o` is the combinational OR of all bits of `req_i`.
- R2: A strobe on `test_i` starts no pass while `any_o` is 0, or while a found result is still unacknowledged. In both cases `busy_o` stays 0 and `valid_o` stays 0.
- R3: In the clock after an accepted strobe, the block is in the scan state with `busy_o` = 1 and `sel_o` = 0. `busy_o` is 1 exactly while the block is scanning.
- R4: During a pass, `sel_o` rises by exactly one per clock while the selected line is inactive and is not the last line.
- R5: The lowest-numbered active line wins. For winner j, `busy_o` is high for exactly j+1 clocks.
- R6: After the winning scan clock, `valid_o` is 1 for exactly one clock, with `line_o` equal to the winner's index. `busy_o` is 0 during that clock.
- R7: If the line at index NUM_LINES-1 is inactive when it is examined, the block returns to idle with no valid pulse, and `line_o` keeps its previous value.
- R8: After a find, `line_o` stays stable until `ack_i` is seen high. A find takes precedence over an acknowledge in the same clock.
- R9: After reset, `busy_o` = 0, `valid_o` = 0, `sel_o` = 0 and `line_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_LINES | Registered interrupt request lines, bit i = line i |
| test_i | input | 1 | Test strobe that starts a pass |
| ack_i | input | 1 | Acknowledge of the reported line |
| any_o | output | 1 | OR of all request lines |
| sel_o | output | IDX_W | Polling select index |
| line_o | output | IDX_W | Number of the last line found |
| valid_o | output | 1 | One-clock pulse marking a find |
| busy_o | output | 1 | High while a pass is scanning |

## Verification
The bench counts the scan clocks for every request pattern and checks that the count equals the winner's index plus one. A design that resolved priority combinationally, or that skipped or repeated an index, would show the wrong count. Patterns where the top line is the only requester, and where the requests drop to zero in mid-pass, exercise the last-index exit. A design that ran past the end or raised a false valid would fail there. Strobes sent before an acknowledge check that a pending result is neither overwritten nor duplicated. Strobes sent with no request pending check that no empty pass is started.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FOUND = 2'd2
    } poll_state_t;
endpackage

// File: rtl/req_any.sv
module req_any #(
    parameter int NUM_LINES = 4
) (
    input  logic [NUM_LINES-1:0] req_i,
    output logic                 any_o
);
    always_comb begin
        any_o = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            any_o = any_o | req_i[i];
        end
    end
endmodule

// File: rtl/req_mux.sv
module req_mux #(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [IDX_W-1:0]     sel_i,
    output logic                 hit_o
);
    logic [NUM_LINES-1:0] onehot;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
            assign onehot[g] = req_i[g] && (sel_i == IDX_W'(g));
        end
    endgenerate

    assign hit_o = |onehot;
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
    import poll_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic             hit_i,
    input  logic             test_i,
    input  logic             ack_i,
    output logic [IDX_W-1:0] sel_o,
    output logic [IDX_W-1:0] line_o,
    output logic             valid_o,
    output logic             busy_o
);
    poll_state_t state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] line_q, line_d;
    logic             pend_q, pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            line_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            line_q  <= line_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = '0;
        line_d  = line_q;
        pend_d  = pend_q && !ack_i;
        unique case (state_q)
            ST_IDLE: begin
                if (test_i && any_i && !pend_q) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (hit_i) begin
                    state_d = ST_FOUND;
                    line_d  = idx_q;
                    pend_d  = 1'b1;
                end else if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_FOUND: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sel_o   = idx_q;
        line_o  = line_q;
        valid_o = (state_q == ST_FOUND);
        busy_o  = (state_q == ST_SCAN);
    end

    // R2
    start_needs_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(any_i && test_i && !pend_q)) |=> state_q == ST_IDLE);

    // R4
    index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !hit_i && idx_q != LAST_IDX)
        |=> (state_q == ST_SCAN && idx_q == IDX_W'($past(idx_q) + 1'b1)));

    // R6
    found_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && hit_i) |=> (valid_o && line_o == $past(idx_q)));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7
    last_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !hit_i && idx_q == LAST_IDX)
        |=> (state_q == ST_IDLE && !valid_o && $stable(line_o)));

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack_i) |=> $stable(line_o));
endmodule

// File: rtl/poll_scanner.sv
module poll_scanner #(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic                 test_i,
    input  logic                 ack_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     sel_o,
    output logic [IDX_W-1:0]     line_o,
    output logic                 valid_o,
    output logic                 busy_o
);
    logic hit;

    req_any #(.NUM_LINES(NUM_LINES)) u_any (
        .req_i (req_i),
        .any_o (any_o)
    );

    req_mux #(.NUM_LINES(NUM_LINES)) u_mux (
        .req_i (req_i),
        .sel_i (sel_o),
        .hit_o (hit)
    );

    poll_fsm #(.NUM_LINES(NUM_LINES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_i   (any_o),
        .hit_i   (hit),
        .test_i  (test_i),
        .ack_i   (ack_i),
        .sel_o   (sel_o),
        .line_o  (line_o),
        .valid_o (valid_o),
        .busy_o  (busy_o)
    );

    // R1
    any_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o == (req_i != '0));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (sel_o == '0 && $past(test_i) && $past(any_o)));
endmodule

// File: tb/tb_poll_scanner.sv
module tb_poll_scanner;
    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         test_i = 1'b0;
    logic         ack_i = 1'b0;
    logic         any_o;
    logic [W-1:0] sel_o;
    logic [W-1:0] line_o;
    logic         valid_o;
    logic         busy_o;

    int compared = 0;
    int mismatched = 0;
    logic [W-1:0] last_line = '0;

    always #10 clk = ~clk;

    poll_scanner #(.NUM_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .test_i(test_i), .ack_i(ack_i),
        .any_o(any_o), .sel_o(sel_o), .line_o(line_o), .valid_o(valid_o), .busy_o(busy_o)
    );

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    // Strobe with a stable pattern; checks R1..R6 and R7/R2 as applicable.
    task automatic poll(input logic [N-1:0] r);
        int win;
        int cnt;
        win = lowest(r);
        req_i = r;
        #1;
        check("R1 any", int'(any_o), int'(r != '0));
        test_i = 1'b1;
        @(negedge clk);
        test_i = 1'b0;
        if (win < 0) begin
            check("R2 no start busy", int'(busy_o), 0);
            check("R2 no start valid", int'(valid_o), 0);
            return;
        end
        check("R3 busy at start", int'(busy_o), 1);
        check("R3 sel zero at start", int'(sel_o), 0);
        cnt = 0;
        while (busy_o && cnt < 10) begin
            check("R4 sel steps", int'(sel_o), cnt);
            cnt++;
            @(negedge clk);
        end
        check("R5 scan clocks", cnt, win + 1);
        check("R6 valid", int'(valid_o), 1);
        check("R6 line", int'(line_o), win);
        last_line = W'(win);
        @(negedge clk);
        check("R6 valid one clock", int'(valid_o), 0);
        check("R8 line held", int'(line_o), win);
    endtask

    initial begin
        #4000000;
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        check("R9 busy", int'(busy_o), 0);
        check("R9 valid", int'(valid_o), 0);
        check("R9 sel", int'(sel_o), 0);
        check("R9 line", int'(line_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no request pending
        poll(4'b0000);
        // directed winners
        poll(4'b0001); do_ack();
        poll(4'b1000); do_ack();
        poll(4'b0110); do_ack();
        poll(4'b1111); do_ack();

        // R2/R8: strobe while result unacknowledged is ignored
        poll(4'b0100);
        req_i = 4'b0001;
        test_i = 1'b1;
        @(negedge clk);
        test_i = 1'b0;
        check("R2 pending blocks busy", int'(busy_o), 0);
        @(negedge clk);
        check("R8 line kept while pending", int'(line_o), 2);
        do_ack();
        poll(4'b0001); do_ack();

        // R7: requests drop during the pass
        req_i = 4'b1000;
        test_i = 1'b1;
        @(negedge clk);
        test_i = 1'b0;
        req_i = 4'b0000;
        begin
            int cnt = 0;
            int saw_valid = 0;
            while (busy_o && cnt < 10) begin
                cnt++;
                @(negedge clk);
            end
            if (valid_o) saw_valid = 1;
            check("R7 full pass length", cnt, N);
            check("R7 no valid", saw_valid, 0);
            check("R7 line unchanged", int'(line_o), 0);
        end
        @(negedge clk);

        // random patterns, sometimes left unacknowledged
        for (int k = 0; k < 80; k++) begin
            logic [N-1:0] r;
            r = N'($urandom);
            poll(r);
            if (r != '0) begin
                if (($urandom % 4) == 0) begin
                    req_i = N'($urandom) | 4'b0001;
                    test_i = 1'b1;
                    @(negedge clk);
                    test_i = 1'b0;
                    check("R2 random pending", int'(busy_o), 0);
                    check("R8 random hold", int'(line_o), int'(last_line));
                end
                do_ack();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule